// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the word address of every memory operand in a 32-bit accumulator-style CPU in which all data addressing modes are indexed. Each request carries a short-form or long-form offset from the instruction, plus a 3-bit selector that picks the base register. The base can be a constant zero, one of four Y registers, Z, the program counter or the stack pointer. The block adds the base and the zero-extended offset with a full 32-bit adder and registers the sum.

The zero base lets the old direct-page and absolute instruction forms keep their meaning. Choosing a real register turns the same encodings into pointer-plus-field accesses. With the stack pointer as base, a parameter stored on the stack is reached in a single step. The sum is never confined to a 256-word page, so a carry out of bit 7 moves into the upper bits. When the program counter is the base, the block adds the current instruction's length in words, so the base is the address of the next instruction. The sum is a word address and is passed on without any byte-lane adjustment.

Top module: `idx_ea_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ea_valid` is 0 and `ea` is 0. A request presented in a cycle where `rst` is high is dropped.
- R2: A request with `req` high at a rising edge makes `ea_valid` high for exactly one cycle after that edge. With `req` low at an edge, `ea_valid` is low after it.
- R3: `base_sel` = 0 uses a base of zero, so `ea` equals the extended offset.
- R4: `base_sel` codes 1 to 4 pick `y_regs` slices 0 to 3, where slice k is bits [32k+31:32k]. Code 5 picks `z_reg` and code 7 picks `sp_reg`.
- R5: `base_sel` = 6 uses `pc_cur + insn_len` as the base, which is the address of the next instruction.
- R6: `mode` = 0 is the short form. The offset is `offset[7:0]` zero-extended to 32 bits, and `offset[15:8]` has no effect on `ea`.
- R7: `mode` = 1 is the long form. The offset is `offset[15:0]` zero-extended to 32 bits.
- R8: The addition spans all 32 bits. A short-form access whose low byte sum passes 0xFF carries into bit 8 and above and does not wrap within the page.
- R9: A sum of 2^32 or more wraps modulo 2^32. The `pc_cur + insn_len` base wraps the same way.
- R10: With `req` low, `ea` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Address request strobe |
| mode | input | 1 | 0 short-form offset, 1 long-form offset |
| base_sel | input | 3 | Base register selector |
| offset | input | 16 | Offset field from the instruction |
| y_regs | input | 128 | Four Y register values, slice k at [32k+31:32k] |
| z_reg | input | 32 | Z register value |
| pc_cur | input | 32 | Address of the current instruction |
| insn_len | input | 3 | Current instruction length in words |
| sp_reg | input | 32 | Stack pointer value |
| ea | output | 32 | Registered effective address |
| ea_valid | output | 1 | One-cycle strobe marking a new `ea` |

## Verification
A request can arrive in the same cycle that reset is held. Reset must win, leaving no valid pulse and a zero address. The bench raises `req` with a nonzero selection while `rst` is high and checks both outputs afterwards. Carry past bit 7 and the 32-bit wrap can also occur in one sum: a short-form offset added to a base near the top of the address space. The bench sweeps every selector and both modes over such operands and compares each result with a sum computed modulo 2^32.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic {
    EA_MODE_SHORT = 1'b0,
    EA_MODE_LONG  = 1'b1
  } ea_mode_t;

  localparam int unsigned EA_SEL_W    = 3;
  localparam int unsigned EA_SEL_ZERO = 0;
  localparam int unsigned EA_SEL_Y0   = 1;
  localparam int unsigned EA_SEL_Z    = 5;
  localparam int unsigned EA_SEL_PC   = 6;
  localparam int unsigned EA_SEL_SP   = 7;
endpackage

// File: rtl/ea_base_mux.sv
module ea_base_mux
  import ea_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NUM_Y = 4,
  parameter int unsigned SW    = EA_SEL_W,
  parameter int unsigned LW    = 3
) (
  input  logic [SW-1:0]       sel,
  input  logic [NUM_Y*AW-1:0] y_flat,
  input  logic [AW-1:0]       z_val,
  input  logic [AW-1:0]       pc_val,
  input  logic [LW-1:0]       len_val,
  input  logic [AW-1:0]       sp_val,
  output logic [AW-1:0]       base
);
  localparam int unsigned NCAND = 1 << SW;

  logic [AW-1:0] cand [NCAND];
  logic [AW-1:0] pc_next;

  assign pc_next = pc_val + {{(AW-LW){1'b0}}, len_val};

  genvar gi;
  generate
    for (gi = 0; gi < NCAND; gi++) begin : g_cand
      if (gi == EA_SEL_ZERO) begin : g_zero
        assign cand[gi] = '0;
      end else if (gi >= EA_SEL_Y0 && gi < EA_SEL_Y0 + NUM_Y) begin : g_y
        assign cand[gi] = y_flat[(gi-EA_SEL_Y0)*AW +: AW];
      end else if (gi == EA_SEL_Z) begin : g_z
        assign cand[gi] = z_val;
      end else if (gi == EA_SEL_PC) begin : g_pc
        assign cand[gi] = pc_next;
      end else if (gi == EA_SEL_SP) begin : g_sp
        assign cand[gi] = sp_val;
      end else begin : g_unused
        assign cand[gi] = '0;
      end
    end
  endgenerate

  assign base = cand[sel];
endmodule

// File: rtl/ea_offset_ext.sv
module ea_offset_ext
  import ea_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned OW   = 16,
  parameter int unsigned SHW  = 8
) (
  input  ea_mode_t       mode,
  input  logic [OW-1:0]  ofs_in,
  output logic [AW-1:0]  ofs_out
);
  always_comb begin
    if (mode == EA_MODE_SHORT) ofs_out = {{(AW-SHW){1'b0}}, ofs_in[SHW-1:0]};
    else                       ofs_out = {{(AW-OW){1'b0}}, ofs_in};
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NUM_Y = 4,
  parameter int unsigned OW    = 16,
  parameter int unsigned SHW   = 8,
  parameter int unsigned LW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                mode,
  input  logic [EA_SEL_W-1:0] base_sel,
  input  logic [OW-1:0]       offset,
  input  logic [NUM_Y*AW-1:0] y_regs,
  input  logic [AW-1:0]       z_reg,
  input  logic [AW-1:0]       pc_cur,
  input  logic [LW-1:0]       insn_len,
  input  logic [AW-1:0]       sp_reg,
  output logic [AW-1:0]       ea,
  output logic                ea_valid
);
  logic [AW-1:0] base_w;
  logic [AW-1:0] ofs_w;
  logic [AW-1:0] sum_w;

  ea_base_mux #(.AW(AW), .NUM_Y(NUM_Y), .SW(EA_SEL_W), .LW(LW)) u_mux (
    .sel     (base_sel),
    .y_flat  (y_regs),
    .z_val   (z_reg),
    .pc_val  (pc_cur),
    .len_val (insn_len),
    .sp_val  (sp_reg),
    .base    (base_w)
  );

  ea_offset_ext #(.AW(AW), .OW(OW), .SHW(SHW)) u_ext (
    .mode    (ea_mode_t'(mode)),
    .ofs_in  (offset),
    .ofs_out (ofs_w)
  );

  assign sum_w = base_w + ofs_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= req;
      if (req) ea <= sum_w;
    end
  end

  // R2: strobe follows a request by one cycle
  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> ea_valid);
  // R2: no strobe without a request
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ea_valid);
  // R10: address held while idle
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(ea));
  // R3 and R6: zero base in short form yields the low offset byte
  a_r3_zero_base_short: assert property (@(posedge clk) disable iff (rst)
    (req && base_sel == 3'd0 && !mode) |=> (ea == {{(AW-SHW){1'b0}}, $past(offset[SHW-1:0])}));
  // R7: zero base in long form yields the whole offset
  a_r7_zero_base_long: assert property (@(posedge clk) disable iff (rst)
    (req && base_sel == 3'd0 && mode) |=> (ea == {{(AW-OW){1'b0}}, $past(offset)}));
  // R4: stack-pointer base adds directly
  a_r4_sp_base: assert property (@(posedge clk) disable iff (rst)
    (req && base_sel == 3'd7 && mode) |=> (ea == $past(sp_reg) + {{(AW-OW){1'b0}}, $past(offset)}));
  // R1: reset clears outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ea_valid && ea == '0));
endmodule

// File: tb/tb_idx_ea_gen.sv
`timescale 1ns/1ps
module tb_idx_ea_gen;
  logic         clk = 1'b0;
  logic         rst;
  logic         req;
  logic         mode;
  logic [2:0]   base_sel;
  logic [15:0]  offset;
  logic [127:0] y_regs;
  logic [31:0]  z_reg, pc_cur, sp_reg;
  logic [2:0]   insn_len;
  logic [31:0]  ea;
  logic         ea_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  idx_ea_gen dut (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .base_sel(base_sel),
    .offset(offset), .y_regs(y_regs), .z_reg(z_reg), .pc_cur(pc_cur),
    .insn_len(insn_len), .sp_reg(sp_reg), .ea(ea), .ea_valid(ea_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] base_of(input int s);
    case (s)
      0: return 32'h0;
      1, 2, 3, 4: return y_regs[(s-1)*32 +: 32];
      5: return z_reg;
      6: return pc_cur + {29'b0, insn_len};
      default: return sp_reg;
    endcase
  endfunction

  function automatic logic [31:0] ofs_of(input logic m, input logic [15:0] o);
    return m ? {16'b0, o} : {24'b0, o[7:0]};
  endfunction

  // present a request at negedge, sample after the capturing edge
  task automatic issue(input int s, input logic m, input logic [15:0] o);
    base_sel = 3'(s); mode = m; offset = o; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ofs_list [5];
    logic [31:0] exp;
    ofs_list[0] = 16'h0000; ofs_list[1] = 16'h00FF; ofs_list[2] = 16'hAB80;
    ofs_list[3] = 16'hFFFF; ofs_list[4] = 16'h1234;
    y_regs = {32'h8000_0000, 32'h1234_5600, 32'hFFFF_FFF0, 32'h0000_00F0};
    z_reg = 32'h0040_0000; pc_cur = 32'h0000_1000; sp_reg = 32'h0000_FF00;
    insn_len = 3'd2;
    rst = 1'b1; req = 1'b0; mode = 1'b0; base_sel = 3'd0; offset = '0;
    @(negedge clk); @(negedge clk);
    // R1: request during reset is dropped
    req = 1'b1; base_sel = 3'd5; offset = 16'h0011;
    @(negedge clk);
    req = 1'b0; rst = 1'b0;
    @(negedge clk);
    check(ea_valid == 1'b0, "R1 valid after reset", {31'b0, ea_valid}, 32'h0);
    check(ea == 32'h0, "R1 ea after reset", ea, 32'h0);

    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 5; k++) begin
          issue(s, 1'(m), ofs_list[k]);
          exp = base_of(s) + ofs_of(1'(m), ofs_list[k]);
          check(ea_valid == 1'b1, "R2 valid pulse", {31'b0, ea_valid}, 32'h1);
          if (s == 0)      check(ea == exp, "R3 zero base", ea, exp);
          else if (s == 6) check(ea == exp, "R5 pc base", ea, exp);
          else             check(ea == exp, "R4 register base", ea, exp);
          @(negedge clk);
          check(ea_valid == 1'b0, "R2 single cycle", {31'b0, ea_valid}, 32'h0);
          check(ea == exp, "R10 hold", ea, exp);
        end
      end
    end

    // R5: sweep instruction length
    for (int l = 0; l < 8; l++) begin
      insn_len = 3'(l);
      issue(6, 1'b1, 16'h0004);
      exp = 32'h0000_1004 + l;
      check(ea == exp, "R5 next-insn base", ea, exp);
    end
    // R6: high byte ignored in short form
    issue(0, 1'b0, 16'hFF3C);
    check(ea == 32'h0000_003C, "R6 high byte ignored", ea, 32'h0000_003C);
    // R7: long form keeps high byte
    issue(0, 1'b1, 16'hFF3C);
    check(ea == 32'h0000_FF3C, "R7 long offset", ea, 32'h0000_FF3C);
    // R8: carry out of bit 7 (Y0 = 0xF0 plus 0x80)
    issue(1, 1'b0, 16'h0080);
    check(ea == 32'h0000_0170, "R8 no page wrap", ea, 32'h0000_0170);
    // R9: wrap past 2^32 (Y1 = FFFFFFF0 plus 0x20)
    issue(2, 1'b0, 16'h0020);
    check(ea == 32'h0000_0010, "R9 modulo wrap", ea, 32'h0000_0010);
    // R9: pc base wraps
    pc_cur = 32'hFFFF_FFFE; insn_len = 3'd3;
    issue(6, 1'b0, 16'h0000);
    check(ea == 32'h0000_0001, "R9 pc wrap", ea, 32'h0000_0001);
    // R10: idle cycles with changing inputs
    base_sel = 3'd7; offset = 16'h5555; sp_reg = 32'h1;
    @(negedge clk); @(negedge clk);
    check(ea == 32'h0000_0001, "R10 idle hold", ea, 32'h0000_0001);
    check(ea_valid == 1'b0, "R2 idle no valid", {31'b0, ea_valid}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule